// File: doc/BRIEF.md
# Video sync signal generator

This block turns the position of a running video raster into the two discrete timing outputs that a video encoder or capture port expects next to the pixel data. A separate pixel/line counter supplies the current pixel index within the line, the line index within the field, a field flag, and a strobe that marks the first half of each pixel. The block runs on a clock at twice the pixel rate. Each pixel therefore lasts two clock cycles, and the horizontal output can be moved in half-pixel steps.

The horizontal output is one of two signals. The first is an active-region reference that is high over the visible pixels. The second is a broadcast-style sync pulse that is low for a fixed number of pixels, starting a short, standard-dependent distance after the last visible pixel of the line. The vertical output is one of three signals. The first is an active-line reference. The second is a broadcast-style sync pulse that is three lines long for the 525-line standard and two and a half lines long for the 625-line standard. The third is a port-style sync that is high for the first six line periods of each field. For this third signal, the edge falls after the horizontal reference edge in odd fields and before it in even fields. Either output can be inverted.

The control pins are taken only at the first half of pixel 0 of each line. A control change in the middle of a line therefore takes effect at the start of the next line, and cannot cut a pulse short.

Top module: `vid_sync_gen`

## Requirements
- R1: While reset is asserted, `h_out` and `v_out` are 0. After reset, the configuration is horizontal reference, vertical reference, 525-line standard, no inversion and no shift, until a new configuration is taken at the next line start.
- R2: With `cfg_hs_sel`=0, the horizontal level is high for pixels `H_BLANK`..`H_TOTAL`-1 and low for pixels 0..`H_BLANK`-1. With no shift, `h_out` shows, two clock cycles later, the level for the position that was presented on the inputs.
- R3: With `cfg_hs_sel`=1, the horizontal level is low for `HS_W` pixels (2*`HS_W` cycles) and high at all other times. The low level starts at pixel `HS_OFS_NTSC` when `cfg_pal`=0, and at pixel `HS_OFS_PAL` when `cfg_pal`=1. Pixel 0 is the first pixel after the last active pixel.
- R4: `cfg_h_shift` = n delays `h_out` by n further clock cycles (n half-pixels, n = 0..3), in both horizontal modes.
- R5: `cfg_h_inv`=1 inverts `h_out` in both horizontal modes.
- R6: With `cfg_zv`=0 and `cfg_vs_sel`=0, the vertical level is low on lines 0..`VB_LINES`-1 of a field and high on later lines, with a latency of two cycles.
- R7: With `cfg_zv`=0 and `cfg_vs_sel`=1, the vertical level is low from pixel 0 of line `VS_START` and high at all other times. When `cfg_pal`=0, the low level lasts `VS_NTSC_LINES` whole lines. When `cfg_pal`=1, it lasts `VS_PAL_FULL` whole lines plus the pixels below `H_TOTAL`/2 of the next line.
- R8: With `cfg_zv`=1, the vertical level is high for exactly `ZV_LINES` line periods, starting in line 0 and ending in line `ZV_LINES`, always at the same pixel. In odd fields (`field_even`=0) that pixel is `H_BLANK`+`ZV_SKEW`, which is after the horizontal reference rise. In even fields it is `H_BLANK`-`ZV_SKEW`, which is before it. `cfg_zv` takes priority over `cfg_vs_sel`.
- R9: `cfg_v_inv`=1 inverts `v_out` in all three vertical modes.
- R10: The control pins are taken only in the cycle where `pix_ce`=1 and `pix_x`=0. That line is decoded with the new values. A change at any other time has no effect on either output until that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | High in the first of the two cycles of each pixel |
| pix_x | input | XW | Pixel index within the line, 0 = first blanking pixel |
| line_y | input | YW | Line index within the field, 0 = first line |
| field_even | input | 1 | 0 in the odd field, 1 in the even field |
| cfg_hs_sel | input | 1 | 1 selects the horizontal sync pulse, 0 the horizontal reference |
| cfg_h_inv | input | 1 | Inverts the horizontal output |
| cfg_h_shift | input | 2 | Horizontal delay in half-pixel steps |
| cfg_vs_sel | input | 1 | 1 selects the broadcast vertical sync, 0 the vertical reference |
| cfg_v_inv | input | 1 | Inverts the vertical output |
| cfg_pal | input | 1 | 1 selects the 625-line placement, 0 the 525-line placement |
| cfg_zv | input | 1 | 1 selects the port-style vertical sync |
| h_out | output | 1 | Horizontal timing output |
| v_out | output | 1 | Vertical timing output |

## Verification
The bench builds the block with a 20-pixel line that has 8 blanking pixels, a 4-pixel sync pulse at offsets 3 and 2, a skew of 2 pixels, and fields of 11 and 12 lines. With these values a whole frame is only 920 cycles. Every horizontal setting and every vertical mode, with both standards, both polarities and both fields, can then be run over complete fields, with pulse widths and edge pixels counted in clock cycles. A third pass walks through all 256 control words and changes them in the middle of a line, so that every transition between modes meets the line-start sampling rule.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  localparam int SHIFT_W = 2;
  localparam int NTAP    = 1 << SHIFT_W;

  typedef struct packed {
    logic               hs_sel;
    logic               h_inv;
    logic [SHIFT_W-1:0] h_shift;
    logic               vs_sel;
    logic               v_inv;
    logic               pal;
    logic               zv;
  } vsg_cfg_t;

endpackage

// File: rtl/vsg_cfg_latch.sv
module vsg_cfg_latch
  import vsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_start,
  input  vsg_cfg_t cfg_in,
  output vsg_cfg_t cfg_q,
  output logic     eff_hs_sel,
  output logic     eff_vs_sel,
  output logic     eff_pal,
  output logic     eff_zv
);

  // Mode selection seen by the decoders in this cycle: new values at a line start.
  always_comb begin
    eff_hs_sel = line_start ? cfg_in.hs_sel : cfg_q.hs_sel;
    eff_vs_sel = line_start ? cfg_in.vs_sel : cfg_q.vs_sel;
    eff_pal    = line_start ? cfg_in.pal    : cfg_q.pal;
    eff_zv     = line_start ? cfg_in.zv     : cfg_q.zv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (line_start) begin
      cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/vsg_hdec.sv
module vsg_hdec #(
  parameter int XW          = 10,
  parameter int H_BLANK     = 138,
  parameter int HS_W        = 64,
  parameter int HS_OFS_NTSC = 16,
  parameter int HS_OFS_PAL  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pix_x,
  input  logic          hs_sel,
  input  logic          pal,
  output logic          h_raw_q
);

  localparam logic [XW-1:0] HB_X    = XW'(H_BLANK);
  localparam logic [XW-1:0] N_BEG_X = XW'(HS_OFS_NTSC);
  localparam logic [XW-1:0] N_END_X = XW'(HS_OFS_NTSC + HS_W);
  localparam logic [XW-1:0] P_BEG_X = XW'(HS_OFS_PAL);
  localparam logic [XW-1:0] P_END_X = XW'(HS_OFS_PAL + HS_W);

  logic [XW-1:0] beg_x;
  logic [XW-1:0] end_x;
  logic          in_pulse;
  logic          h_raw_d;

  always_comb begin
    beg_x    = pal ? P_BEG_X : N_BEG_X;
    end_x    = pal ? P_END_X : N_END_X;
    in_pulse = (pix_x >= beg_x) && (pix_x < end_x);
    h_raw_d  = hs_sel ? ~in_pulse : (pix_x >= HB_X);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_raw_q <= 1'b0;
    end else begin
      h_raw_q <= h_raw_d;
    end
  end

endmodule

// File: rtl/vsg_vdec.sv
module vsg_vdec #(
  parameter int XW            = 10,
  parameter int YW            = 9,
  parameter int H_TOTAL       = 858,
  parameter int H_BLANK       = 138,
  parameter int VB_LINES      = 19,
  parameter int VS_START      = 3,
  parameter int VS_NTSC_LINES = 3,
  parameter int VS_PAL_FULL   = 2,
  parameter int ZV_LINES      = 6,
  parameter int ZV_SKEW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] line_y,
  input  logic          field_even,
  input  logic          vs_sel,
  input  logic          pal,
  input  logic          zv,
  output logic          v_raw_q
);

  localparam logic [XW-1:0] HALF_X    = XW'(H_TOTAL / 2);
  localparam logic [XW-1:0] ZV_ODD_X  = XW'(H_BLANK + ZV_SKEW);
  localparam logic [XW-1:0] ZV_EVEN_X = XW'(H_BLANK - ZV_SKEW);
  localparam logic [YW-1:0] VB_Y      = YW'(VB_LINES);
  localparam logic [YW-1:0] VS_BEG_Y  = YW'(VS_START);
  localparam logic [YW-1:0] VS_N_END  = YW'(VS_START + VS_NTSC_LINES);
  localparam logic [YW-1:0] VS_P_END  = YW'(VS_START + VS_PAL_FULL);
  localparam logic [YW-1:0] ZV_LAST_Y = YW'(ZV_LINES);

  logic [XW-1:0] zv_x;
  logic          zv_lvl;
  logic          vs_n;
  logic          vs_p;
  logic          v_raw_d;

  always_comb begin
    zv_x   = field_even ? ZV_EVEN_X : ZV_ODD_X;
    zv_lvl = ((line_y == '0) && (pix_x >= zv_x)) ||
             ((line_y != '0) && (line_y < ZV_LAST_Y)) ||
             ((line_y == ZV_LAST_Y) && (pix_x < zv_x));
    vs_n   = (line_y >= VS_BEG_Y) && (line_y < VS_N_END);
    vs_p   = ((line_y >= VS_BEG_Y) && (line_y < VS_P_END)) ||
             ((line_y == VS_P_END) && (pix_x < HALF_X));
    if (zv) begin
      v_raw_d = zv_lvl;
    end else if (vs_sel) begin
      v_raw_d = pal ? ~vs_p : ~vs_n;
    end else begin
      v_raw_d = (line_y >= VB_Y);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_raw_q <= 1'b0;
    end else begin
      v_raw_q <= v_raw_d;
    end
  end

endmodule

// File: rtl/vsg_hshift.sv
module vsg_hshift
  import vsg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               d,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               inv,
  output logic               q
);

  logic [NTAP-2:0] dly_q;
  logic [NTAP-1:0] tap;
  logic            q_d;

  generate
    if (NTAP > 2) begin : g_long
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dly_q <= '0;
        end else begin
          dly_q <= {dly_q[NTAP-3:0], d};
        end
      end
    end else begin : g_short
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dly_q <= '0;
        end else begin
          dly_q <= d;
        end
      end
    end
  endgenerate

  always_comb begin
    tap = {dly_q, d};
    q_d = tap[shift] ^ inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
  import vsg_pkg::*;
#(
  parameter int XW            = 10,
  parameter int YW            = 9,
  parameter int H_TOTAL       = 858,
  parameter int H_BLANK       = 138,
  parameter int HS_W          = 64,
  parameter int HS_OFS_NTSC   = 16,
  parameter int HS_OFS_PAL    = 12,
  parameter int VB_LINES      = 19,
  parameter int VS_START      = 3,
  parameter int VS_NTSC_LINES = 3,
  parameter int VS_PAL_FULL   = 2,
  parameter int ZV_LINES      = 6,
  parameter int ZV_SKEW       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_ce,
  input  logic [XW-1:0]      pix_x,
  input  logic [YW-1:0]      line_y,
  input  logic               field_even,
  input  logic               cfg_hs_sel,
  input  logic               cfg_h_inv,
  input  logic [SHIFT_W-1:0] cfg_h_shift,
  input  logic               cfg_vs_sel,
  input  logic               cfg_v_inv,
  input  logic               cfg_pal,
  input  logic               cfg_zv,
  output logic               h_out,
  output logic               v_out
);

  logic     line_start;
  vsg_cfg_t cfg_in;
  vsg_cfg_t cfg_q;
  logic     eff_hs_sel;
  logic     eff_vs_sel;
  logic     eff_pal;
  logic     eff_zv;
  logic     h_raw_q;
  logic     v_raw_q;
  logic     v_out_d;

  always_comb begin
    line_start     = pix_ce && (pix_x == '0);
    cfg_in.hs_sel  = cfg_hs_sel;
    cfg_in.h_inv   = cfg_h_inv;
    cfg_in.h_shift = cfg_h_shift;
    cfg_in.vs_sel  = cfg_vs_sel;
    cfg_in.v_inv   = cfg_v_inv;
    cfg_in.pal     = cfg_pal;
    cfg_in.zv      = cfg_zv;
    v_out_d        = v_raw_q ^ cfg_q.v_inv;
  end

  vsg_cfg_latch u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .cfg_in     (cfg_in),
    .cfg_q      (cfg_q),
    .eff_hs_sel (eff_hs_sel),
    .eff_vs_sel (eff_vs_sel),
    .eff_pal    (eff_pal),
    .eff_zv     (eff_zv)
  );

  vsg_hdec #(
    .XW(XW), .H_BLANK(H_BLANK), .HS_W(HS_W),
    .HS_OFS_NTSC(HS_OFS_NTSC), .HS_OFS_PAL(HS_OFS_PAL)
  ) u_hdec (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_x   (pix_x),
    .hs_sel  (eff_hs_sel),
    .pal     (eff_pal),
    .h_raw_q (h_raw_q)
  );

  vsg_vdec #(
    .XW(XW), .YW(YW), .H_TOTAL(H_TOTAL), .H_BLANK(H_BLANK),
    .VB_LINES(VB_LINES), .VS_START(VS_START), .VS_NTSC_LINES(VS_NTSC_LINES),
    .VS_PAL_FULL(VS_PAL_FULL), .ZV_LINES(ZV_LINES), .ZV_SKEW(ZV_SKEW)
  ) u_vdec (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_x      (pix_x),
    .line_y     (line_y),
    .field_even (field_even),
    .vs_sel     (eff_vs_sel),
    .pal        (eff_pal),
    .zv         (eff_zv),
    .v_raw_q    (v_raw_q)
  );

  vsg_hshift u_hshift (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (h_raw_q),
    .shift (cfg_q.h_shift),
    .inv   (cfg_q.h_inv),
    .q     (h_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
    end else begin
      v_out <= v_out_d;
    end
  end

endmodule

// File: rtl/vsg_checker.sv
module vsg_checker
  import vsg_pkg::*;
#(
  parameter int XW            = 10,
  parameter int YW            = 9,
  parameter int H_BLANK       = 138,
  parameter int VB_LINES      = 19,
  parameter int VS_START      = 3,
  parameter int VS_NTSC_LINES = 3,
  parameter int ZV_LINES      = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] line_y,
  input vsg_cfg_t      cfg_q,
  input logic          h_out,
  input logic          v_out
);

  // R2: reference mode, no shift, no inversion: visible pixels give a high output two cycles on
  a_r2_href_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.hs_sel && !cfg_q.h_inv && (cfg_q.h_shift == '0) && !line_start &&
     (pix_x >= XW'(H_BLANK))) |-> ##2 h_out);

  // R6: vertical reference is low on blanking lines
  a_r6_vref_blank_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.zv && !cfg_q.vs_sel && !cfg_q.v_inv && !line_start &&
     (line_y < YW'(VB_LINES))) |-> ##2 !v_out);

  // R7: 525-line vertical sync is low over its whole lines
  a_r7_vsync_ntsc_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.zv && cfg_q.vs_sel && !cfg_q.pal && !cfg_q.v_inv && !line_start &&
     (line_y >= YW'(VS_START)) && (line_y < YW'(VS_START + VS_NTSC_LINES)))
    |-> ##2 !v_out);

  // R8: port-style sync is high on the inner lines of its window
  a_r8_zv_mid_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.zv && !cfg_q.v_inv && !line_start && (line_y != '0) &&
     (line_y < YW'(ZV_LINES))) |-> ##2 v_out);

  // R10: the held configuration moves only at a line start
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(cfg_q));

endmodule

bind vid_sync_gen vsg_checker #(
  .XW(XW), .YW(YW), .H_BLANK(H_BLANK), .VB_LINES(VB_LINES),
  .VS_START(VS_START), .VS_NTSC_LINES(VS_NTSC_LINES), .ZV_LINES(ZV_LINES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .pix_x      (pix_x),
  .line_y     (line_y),
  .cfg_q      (cfg_q),
  .h_out      (h_out),
  .v_out      (v_out)
);

// File: tb/vid_sync_gen_tb.sv
module vid_sync_gen_tb;
  import vsg_pkg::*;

  localparam int XW = 5, YW = 4;
  localparam int HT = 20, HB = 8, HSW = 4, OFS_N = 3, OFS_P = 2;
  localparam int VB = 9, VSS = 2, VSN = 3, VSP = 2, ZVL = 6, SK = 2;
  localparam int L_ODD = 11, L_EVEN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0;
  logic [XW-1:0] pix_x = '0;
  logic [YW-1:0] line_y = '0;
  logic field_even = 1'b0;
  vsg_cfg_t cfg_drv = '0;
  logic h_out, v_out;

  always #2 clk = ~clk;

  vid_sync_gen #(
    .XW(XW), .YW(YW), .H_TOTAL(HT), .H_BLANK(HB), .HS_W(HSW),
    .HS_OFS_NTSC(OFS_N), .HS_OFS_PAL(OFS_P), .VB_LINES(VB), .VS_START(VSS),
    .VS_NTSC_LINES(VSN), .VS_PAL_FULL(VSP), .ZV_LINES(ZVL), .ZV_SKEW(SK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .pix_x(pix_x), .line_y(line_y),
    .field_even(field_even), .cfg_hs_sel(cfg_drv.hs_sel), .cfg_h_inv(cfg_drv.h_inv),
    .cfg_h_shift(cfg_drv.h_shift), .cfg_vs_sel(cfg_drv.vs_sel), .cfg_v_inv(cfg_drv.v_inv),
    .cfg_pal(cfg_drv.pal), .cfg_zv(cfg_drv.zv), .h_out(h_out), .v_out(v_out)
  );

  int checks = 0, failures = 0;
  int k = 0, ph = 0, px = 0, ly = 0, fe = 0;
  bit hraw_h [8];
  bit vraw_h [8];
  vsg_cfg_t eff_h [8];
  int pos_h [8];
  bit exp_h = 1'b0, exp_v = 1'b0;
  vsg_cfg_t exp_e = '0;
  bit mid_line = 1'b0, widths_on = 1'b0;
  int seg_cnt = 0;
  int h_len = 0, v_len = 0;
  bit h_ok = 1'b0, v_ok = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit hdec(int x, vsg_cfg_t c);
    int o;
    if (c.hs_sel) begin
      o = c.pal ? OFS_P : OFS_N;
      return !(x >= o && x < o + HSW);
    end
    return x >= HB;
  endfunction

  function automatic bit vdec(int x, int y, int f, vsg_cfg_t c);
    int b;
    bit p;
    if (c.zv) begin
      b = f ? HB - SK : HB + SK;
      return (y == 0 && x >= b) || (y >= 1 && y < ZVL) || (y == ZVL && x < b);
    end
    if (c.vs_sel) begin
      if (c.pal) p = (y >= VSS && y < VSS + VSP) || (y == VSS + VSP && x < HT / 2);
      else       p = (y >= VSS && y < VSS + VSN);
      return !p;
    end
    return y >= VB;
  endfunction

  function automatic string htag(vsg_cfg_t c, bit m);
    string s;
    s = c.hs_sel ? "R3" : "R2";
    if (c.h_shift != 0) s = {s, " R4"};
    if (c.h_inv) s = {s, " R5"};
    if (m) s = {s, " R10"};
    return s;
  endfunction

  function automatic string vtag(vsg_cfg_t c, bit m);
    string s;
    s = c.zv ? "R8" : (c.vs_sel ? "R7" : "R6");
    if (c.v_inv) s = {s, " R9"};
    if (m) s = {s, " R10"};
    return s;
  endfunction

  task automatic track();
    bit ha, va;
    int b, p, f, x, hw, vw;
    ha = exp_e.hs_sel ? (h_out == exp_e.h_inv) : (h_out != exp_e.h_inv);
    hw = exp_e.hs_sel ? 2 * HSW : 2 * (HT - HB);
    if (ha) begin
      if (h_len == 0) h_ok = widths_on && (seg_cnt > 10);
      h_len++;
    end else begin
      if (h_len > 0 && h_ok) chk(h_len == hw, exp_e.hs_sel ? "R3 width" : "R2 width", h_len, hw);
      h_len = 0;
    end
    if (exp_e.zv || exp_e.vs_sel) begin
      va = exp_e.zv ? (v_out != exp_e.v_inv) : (v_out == exp_e.v_inv);
      vw = exp_e.zv ? ZVL * 2 * HT : (exp_e.pal ? VSP * 2 * HT + HT : VSN * 2 * HT);
      if (va) begin
        if (v_len == 0) begin
          v_ok = widths_on && (seg_cnt > 10);
          if (v_ok && exp_e.zv) begin
            p = pos_h[(k + 6) % 8];
            f = p / 1000; x = (p % 1000) / 2;
            b = f ? HB - SK : HB + SK;
            chk((p % 2 == 0) && x == b, "R8 edge pixel", p % 1000, 2 * b);
          end
        end
        v_len++;
      end else begin
        if (v_len > 0 && v_ok) chk(v_len == vw, exp_e.zv ? "R8 width" : "R7 width", v_len, vw);
        v_len = 0;
      end
    end else begin
      v_len = 0;
    end
  endtask

  task automatic step();
    vsg_cfg_t e, eff;
    bit ls;
    @(negedge clk);
    chk(h_out === exp_h, htag(exp_e, mid_line), int'(h_out), int'(exp_h));
    chk(v_out === exp_v, vtag(exp_e, mid_line), int'(v_out), int'(exp_v));
    track();
    if (!rst_n) rst_n = 1'b1;
    e = eff_h[(k + 7) % 8];
    exp_e = e;
    exp_h = hraw_h[(k + 7 - int'(e.h_shift)) % 8] ^ e.h_inv;
    exp_v = vraw_h[(k + 7) % 8] ^ e.v_inv;
    pix_ce = (ph == 0);
    pix_x = XW'(px);
    line_y = YW'(ly);
    field_even = fe[0];
    ls = (ph == 0) && (px == 0);
    eff = ls ? cfg_drv : e;
    hraw_h[k % 8] = hdec(px, eff);
    vraw_h[k % 8] = vdec(px, ly, fe, eff);
    eff_h[k % 8] = eff;
    pos_h[k % 8] = fe * 1000 + px * 2 + ph;
    k++;
    seg_cnt++;
    if (ph == 1) begin
      ph = 0;
      px++;
      if (px == HT) begin
        px = 0;
        ly++;
        if (ly == (fe ? L_EVEN : L_ODD)) begin
          ly = 0;
          fe = 1 - fe;
        end
      end
    end else begin
      ph = 1;
    end
  endtask

  task automatic apply_at_line(input vsg_cfg_t c);
    while (!(ph == 0 && px == 0)) step();
    cfg_drv = c;
    seg_cnt = 0;
    h_ok = 1'b0;
    v_ok = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vsg_cfg_t c;
    for (int i = 0; i < 8; i++) begin
      hraw_h[i] = 1'b0; vraw_h[i] = 1'b0; eff_h[i] = '0; pos_h[i] = 0;
    end
    // R1: outputs low while reset is held, even with a non-default control word
    cfg_drv = 8'hFF;
    repeat (4) begin
      @(negedge clk);
      chk(h_out === 1'b0, "R1 h_out in reset", int'(h_out), 0);
      chk(v_out === 1'b0, "R1 v_out in reset", int'(v_out), 0);
    end
    cfg_drv = '0;
    widths_on = 1'b1;
    // R1 default configuration, then R2..R5 over every horizontal setting
    for (int i = 0; i < 32; i++) begin
      c = '0;
      c.hs_sel = i[4]; c.h_inv = i[3]; c.h_shift = i[2:1]; c.pal = i[0];
      apply_at_line(c);
      repeat (3 * 2 * HT) step();
    end
    // R6..R9 over every vertical mode, standard and polarity, both fields
    for (int i = 0; i < 12; i++) begin
      c = '0;
      c.zv = (i / 4 == 2); c.vs_sel = (i / 4 == 1);
      c.pal = i[1]; c.v_inv = i[0];
      c.hs_sel = i[2]; c.h_shift = i[1:0]; c.h_inv = i[3];
      apply_at_line(c);
      repeat (2 * (L_ODD + L_EVEN) * 2 * HT) step();
    end
    // R10: every control word, changed in the middle of a line
    widths_on = 1'b0;
    mid_line = 1'b1;
    for (int i = 0; i < 256; i++) begin
      while (!(px == 5 && ph == 1)) step();
      cfg_drv = vsg_cfg_t'(i[7:0]);
      step();
    end
    repeat (4 * 2 * HT) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule